// File: doc/BRIEF.md
# PCI System Error Reporter

This block watches the error events raised by a PCI interface and decides when to pulse the bus system-error line. There are five error sources: address parity failure, data parity failure, target-abort received, master-abort, and a general catastrophic-fault input. Two of them depend on the bus command that was in progress. A data parity failure only counts when the command is a special cycle. A master-abort counts for every command except configuration reads, configuration writes and special cycles.

An event that meets its command rule is called qualified. Every qualified event sets its own sticky status bit. If the source's report enable is also set, the event starts a system-error pulse. The pulse appears as an active-low level on `serr_n` together with a drive enable `serr_oe`, so that an open-drain pad can be built from the pair. The pulse lasts `PULSE_LEN` clocks and its length is fixed. Software clears status bits with a write-one-to-clear strobe vector.

The control is a two-state machine:
- `ST_IDLE` is the released state.
- `ST_DRIVE` is the driving state.
- Transition `IDLE->DRIVE` happens when an enabled qualified event is seen.
- Transition `DRIVE->DRIVE` happens while the pulse counter has not reached `PULSE_LEN-1`.
- Transition `DRIVE->IDLE` happens when the counter reaches that value.

Top module: `serr_reporter`

## Requirements
- R1: After reset, `serr_n` is 1, `serr_oe` is 0 and `status` is all zero.
- R2: An address parity error (source bit 0) is always qualified.
- R3: A data parity error (source bit 1) is qualified only when `cmd` is 4'b0001, the special-cycle command.
- R4: A received target-abort (source bit 2) is always qualified.
- R5: A master-abort (source bit 3) is qualified for any `cmd` other than 4'b0001, 4'b1010 and 4'b1011. The last two are configuration read and configuration write.
- R6: The catastrophic-fault input (source bit 4) is always qualified.
- R7: Suppose that at a clock edge in `ST_IDLE` some source is qualified and its `report_en` bit is set. From the next cycle, `serr_n` is 0 and `serr_oe` is 1 for exactly `PULSE_LEN` cycles, and then both are released.
- R8: Events sampled while in `ST_DRIVE` neither extend nor restart the pulse. A new pulse can start from the first `ST_IDLE` cycle after it.
- R9: A qualified event sets its `status` bit in the next cycle whether or not its enable is set. A qualified event whose `report_en` bit is clear never drives the output.
- R10: A `status` bit holds until its `status_clr` bit is 1 at a clock edge, and reads 0 from the next cycle. If a set and a clear arrive at the same edge, the set wins.
- R11: A data parity error or master-abort that is not qualified changes neither `status` nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command of the transaction the event belongs to |
| addr_par_err | input | 1 | Address parity error event |
| data_par_err | input | 1 | Data parity error event |
| target_abort | input | 1 | Target-abort received event |
| master_abort | input | 1 | Master-abort event |
| fatal_err | input | 1 | Other catastrophic error event |
| report_en | input | 5 | Per-source report enable, bit order as in R2 to R6 |
| status_clr | input | 5 | Write-one-to-clear strobe per status bit |
| serr_n | output | 1 | System error, active low |
| serr_oe | output | 1 | Drive enable for the open-drain pad |
| status | output | 5 | Sticky per-source status, bit order as in R2 to R6 |

## Verification
Both `status` and the pulse are registered, so each result first shows one clock after the edge that sampled the event or the clear. The pulse then lasts `PULSE_LEN` cycles, and the bench uses 2. The bench changes inputs just after a rising edge. A behavioural model steps on the same rising edge, and all three outputs are compared against that model at every falling edge. This way each comparison falls in the cycle a result is due, neither early nor late. The stimulus includes back-to-back events, which show that events sampled during the pulse are absorbed.

// File: rtl/serr_pkg.sv
package serr_pkg;
    localparam int NSRC      = 5;
    localparam int SRC_APAR  = 0;
    localparam int SRC_DPAR  = 1;
    localparam int SRC_TABT  = 2;
    localparam int SRC_MABT  = 3;
    localparam int SRC_FATAL = 4;

    localparam logic [3:0] CMD_SPECIAL = 4'b0001;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } serr_state_e;
endpackage

// File: rtl/serr_qualify.sv
module serr_qualify
    import serr_pkg::*;
(
    input  logic [3:0]      cmd,
    input  logic [NSRC-1:0] raw_evt,
    input  logic [NSRC-1:0] report_en,
    output logic [NSRC-1:0] qual,
    output logic            fire
);
    logic is_special;
    logic is_cfg;

    always_comb begin
        is_special = (cmd == CMD_SPECIAL);
        is_cfg     = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        qual            = raw_evt;
        qual[SRC_DPAR]  = raw_evt[SRC_DPAR] & is_special;
        qual[SRC_MABT]  = raw_evt[SRC_MABT] & ~is_special & ~is_cfg;
        fire            = |(qual & report_en);
    end
endmodule

// File: rtl/serr_status.sv
module serr_status
    import serr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] status
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (set_i[i])
                status[i] <= 1'b1;
            else if (clr_i[i])
                status[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/serr_pulse_fsm.sv
module serr_pulse_fsm
    import serr_pkg::*;
#(
    parameter int PULSE_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic serr_n,
    output logic serr_oe
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    serr_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic done;

    assign done = (cnt == LAST);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (fire) state_nxt = ST_DRIVE;
            ST_DRIVE: if (done) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (state == ST_DRIVE && !done)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    always_comb begin
        serr_n  = 1'b1;
        serr_oe = 1'b0;
        unique case (state)
            ST_IDLE:  begin serr_n = 1'b1; serr_oe = 1'b0; end
            ST_DRIVE: begin serr_n = 1'b0; serr_oe = 1'b1; end
            default:  begin serr_n = 1'b1; serr_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/serr_reporter.sv
module serr_reporter
    import serr_pkg::*;
#(
    parameter int PULSE_LEN = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      cmd,
    input  logic            addr_par_err,
    input  logic            data_par_err,
    input  logic            target_abort,
    input  logic            master_abort,
    input  logic            fatal_err,
    input  logic [NSRC-1:0] report_en,
    input  logic [NSRC-1:0] status_clr,
    output logic            serr_n,
    output logic            serr_oe,
    output logic [NSRC-1:0] status
);
    logic [NSRC-1:0] raw_evt;
    logic [NSRC-1:0] qual;
    logic            fire;

    always_comb begin
        raw_evt            = '0;
        raw_evt[SRC_APAR]  = addr_par_err;
        raw_evt[SRC_DPAR]  = data_par_err;
        raw_evt[SRC_TABT]  = target_abort;
        raw_evt[SRC_MABT]  = master_abort;
        raw_evt[SRC_FATAL] = fatal_err;
    end

    serr_qualify u_qual (
        .cmd       (cmd),
        .raw_evt   (raw_evt),
        .report_en (report_en),
        .qual      (qual),
        .fire      (fire)
    );

    serr_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (qual),
        .clr_i  (status_clr),
        .status (status)
    );

    serr_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .serr_n  (serr_n),
        .serr_oe (serr_oe)
    );
endmodule

// File: rtl/serr_reporter_chk.sv
module serr_reporter_chk #(
    parameter int PULSE_LEN = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       addr_par_err,
    input logic       data_par_err,
    input logic       target_abort,
    input logic       master_abort,
    input logic       fatal_err,
    input logic [4:0] report_en,
    input logic [4:0] status_clr,
    input logic       serr_n,
    input logic       serr_oe,
    input logic [4:0] status
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= 0;
        else if (serr_oe)
            low_run <= low_run + 1;
        else
            low_run <= 0;
    end

    // R7: an enabled address parity error in idle drives the line next cycle
    assert_apar_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_n && addr_par_err && report_en[0]) |=> !serr_n);

    // R8: the pulse never runs longer than PULSE_LEN cycles
    assert_pulse_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= PULSE_LEN);

    // R9: nothing enabled means no new pulse can start
    assert_no_enable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_n && report_en == 5'b0) |=> serr_n);

    // R4: target-abort always records status
    assert_tabt_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        target_abort |=> status[2]);

    // R10: status holds without a clear
    assert_apar_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !status_clr[0]) |=> status[0]);

    // R10: clear with no concurrent event empties the bit
    assert_fatal_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr[4] && !fatal_err) |=> !status[4]);

    // R3: data parity on another command leaves its status alone
    assert_dpar_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_par_err && cmd != 4'b0001 && !status_clr[1]) |=> status[1] == $past(status[1]));

    // R5: master-abort on configuration or special cycle leaves its status alone
    assert_mabt_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_abort && (cmd == 4'b1010 || cmd == 4'b1011 || cmd == 4'b0001) && !status_clr[3])
        |=> status[3] == $past(status[3]));
endmodule

bind serr_reporter serr_reporter_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .addr_par_err (addr_par_err),
    .data_par_err (data_par_err),
    .target_abort (target_abort),
    .master_abort (master_abort),
    .fatal_err    (fatal_err),
    .report_en    (report_en),
    .status_clr   (status_clr),
    .serr_n       (serr_n),
    .serr_oe      (serr_oe),
    .status       (status)
);

// File: tb/tb_serr_reporter.sv
`timescale 1ns/1ps
module tb_serr_reporter;
    localparam int PL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'h0;
    logic [4:0] evt = 5'h0;
    logic [4:0] report_en = 5'h1F;
    logic [4:0] status_clr = 5'h0;
    logic       serr_n, serr_oe;
    logic [4:0] status;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit cmp_on = 0;

    logic [4:0] m_status;
    int         m_left;

    always #4 clk = ~clk;

    serr_reporter #(.PULSE_LEN(PL)) dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .addr_par_err(evt[0]), .data_par_err(evt[1]), .target_abort(evt[2]),
        .master_abort(evt[3]), .fatal_err(evt[4]),
        .report_en(report_en), .status_clr(status_clr),
        .serr_n(serr_n), .serr_oe(serr_oe), .status(status)
    );

    function automatic logic [4:0] model_qual(input logic [4:0] e, input logic [3:0] c);
        logic [4:0] r;
        r = e;
        if (c != 4'b0001) r[1] = 1'b0;
        if (c == 4'b0001 || c == 4'b1010 || c == 4'b1011) r[3] = 1'b0;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_status <= 5'h0;
            m_left   <= 0;
        end else begin
            m_status <= (m_status & ~status_clr) | model_qual(evt, cmd);
            if (m_left > 0)
                m_left <= m_left - 1;
            else if ((model_qual(evt, cmd) & report_en) != 5'h0)
                m_left <= PL;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(cur_req, "serr_n", serr_n, (m_left == 0) ? 1 : 0);
            check(cur_req, "serr_oe", serr_oe, (m_left != 0) ? 1 : 0);
            check(cur_req, "status", status, m_status);
        end
    end

    task automatic ev(input logic [4:0] e, input logic [3:0] c, input logic [4:0] en,
                      input logic [4:0] clr);
        evt = e; cmd = c; report_en = en; status_clr = clr;
        @(posedge clk); #2;
        evt = 5'h0; status_clr = 5'h0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        check("R1", "serr_n", serr_n, 1);
        check("R1", "serr_oe", serr_oe, 0);
        check("R1", "status", status, 0);
        rst_n = 1'b1;
        idle(1);
        cmp_on = 1;

        cur_req = "R2";  ev(5'b00001, 4'h0, 5'h1F, 5'h0); idle(4);
        cur_req = "R3";  ev(5'b00010, 4'b0001, 5'h1F, 5'h0); idle(4);
        cur_req = "R11"; ev(5'b00010, 4'b0110, 5'h1F, 5'h1F); idle(4);
        cur_req = "R4";  ev(5'b00100, 4'h0, 5'h1F, 5'h0); idle(4);
        cur_req = "R6";  ev(5'b10000, 4'h0, 5'h1F, 5'h0); idle(4);
        cur_req = "R5";  ev(5'b01000, 4'b0110, 5'h1F, 5'h0); idle(4);
        cur_req = "R11"; ev(5'h0, 4'h0, 5'h1F, 5'h1F); idle(1);
        ev(5'b01000, 4'b1010, 5'h1F, 5'h0); idle(4);
        ev(5'b01000, 4'b1011, 5'h1F, 5'h0); idle(4);
        ev(5'b01000, 4'b0001, 5'h1F, 5'h0); idle(4);
        cur_req = "R9";  ev(5'b11111, 4'b0001, 5'h00, 5'h0); idle(4);
        ev(5'b01000, 4'h0, 5'h00, 5'h0); idle(2);
        cur_req = "R7";  ev(5'h0, 4'h0, 5'b00100, 5'h1F); idle(1);
        ev(5'b00001, 4'h0, 5'b00100, 5'h0); idle(3);
        ev(5'b00100, 4'h0, 5'b00100, 5'h0); idle(4);
        cur_req = "R10"; ev(5'b00001, 4'h0, 5'h1F, 5'b00001); idle(4);
        ev(5'h0, 4'h0, 5'h1F, 5'h1F); idle(2);
        cur_req = "R8";  ev(5'b00001, 4'h0, 5'h1F, 5'h0);
        ev(5'b00100, 4'h0, 5'h1F, 5'h0);
        ev(5'b10000, 4'h0, 5'h1F, 5'h0);
        ev(5'b00001, 4'h0, 5'h1F, 5'h0); idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule